// File: doc/BRIEF.md
# Per-Locality Interrupt Enable and Status Unit

This unit keeps one interrupt-enable register and one interrupt-status register for each of five localities, and drives a single interrupt line that all localities share. The arbiter and the command controller send it one-cycle event pulses: a locality change, command ready, data available and status valid. Each group of pulses names a target locality. A pulse is latched into that locality's status register only when the locality's master enable bit and the enable bit for that source are both set. Any latched event drives the shared line high.

Software reaches the registers through a simple write port and a combinational read port. A write carries a locality, a register select and byte-lane enables. Only the locality that currently owns the interface may change its enable or status register. Writes from any other locality, and all writes while no locality owns the interface, are dropped. Status bits are cleared by writing ones to them. The line drops when the clearing locality's status reaches zero, whatever the other localities still hold. The vector register is read-only and returns the line number fixed at build time. The polarity field is only stored; it has no effect on the line.

Top module: `loc_irq_unit`

## Requirements
- R1: After reset every enable register reads 0x0000_0010 (polarity field = 01, all enables clear), every status register reads 0, and `irq` is low.
- R2: An event pulse addressed to a valid locality whose enable bit 31 (master) and matching source bit are both set sets that status bit and drives `irq` high from the next clock edge. The source bits sit at bit 0 (locality changed), bit 1 (command ready), bit 2 (data available) and bit 3 (status valid), in both the status and the enable register.
- R3: An event pulse whose master enable or source enable is clear leaves the status unchanged and does not raise `irq`.
- R4: An event addressed to a locality code of 5 or higher is discarded.
- R5: A write to the enable or status register is ignored unless `wr_loc` equals `active_loc` and `active_loc` is below 5.
- R6: In the enable register only bit 31, the polarity field at bits 5:4 and the source bits 3:0 can be written. All other bits read 0.
- R7: Writing a 1 to a status bit in 3:0 clears it, and writing a 1 to any other bit has no effect. If the write hits a set bit and leaves that locality's status at zero, `irq` goes low. Otherwise `irq` is unchanged.
- R8: Only the bytes whose `wr_be` bit is set are affected by a write: bit n covers data bits 8n+7:8n.
- R9: Register select 2 reads the parameter IRQ_LINE (0 to 15) for any locality, and writes to it are ignored.
- R10: When an event latches in the same cycle as a clearing write, the event wins: the bit it sets ends up set and `irq` stays high.
- R11: The line drops when the clearing locality's status reaches zero, even if another locality still holds status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active_loc | input | 3 | Locality that owns the interface; 5 or more means none |
| evt_loc | input | 3 | Target locality of this cycle's event pulses |
| evt_lc | input | 1 | Locality-changed event pulse |
| evt_cr | input | 1 | Command-ready event pulse |
| evt_da | input | 1 | Data-available event pulse |
| evt_sv | input | 1 | Status-valid event pulse |
| wr_en | input | 1 | Register write strobe |
| wr_loc | input | 3 | Locality issuing the write |
| wr_sel | input | 2 | Register select: 0 enable, 1 status, 2 vector |
| wr_be | input | 4 | Byte-lane enables |
| wr_data | input | 32 | Write data |
| rd_loc | input | 3 | Locality to read |
| rd_sel | input | 2 | Register select for read |
| rd_data | output | 32 | Read data, combinational from state |
| irq | output | 1 | Shared interrupt line, active high |

## Verification
An event latch and a write-one-to-clear can land in the same cycle, on the same locality or on different ones. Both then decide the next status word and the next line level. The bench drives an event pulse and a clearing status write in one cycle. It does this once with both aimed at the same bit and once with different bits. On the following cycle it checks that the status keeps the event's bit and that the line stays high. It also clears one locality while another still holds status bits, and checks that the line drops anyway.

// File: rtl/loc_irq_unit.sv
module loc_irq_unit #(
  parameter int NUM_LOC  = 5,
  parameter int LOC_W    = 3,
  parameter int IRQ_LINE = 5,
  parameter int POL_LSB  = 4,
  parameter int POL_W    = 2,
  parameter int GEN_BIT  = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LOC_W-1:0] active_loc,
  input  logic [LOC_W-1:0] evt_loc,
  input  logic             evt_lc,
  input  logic             evt_cr,
  input  logic             evt_da,
  input  logic             evt_sv,
  input  logic             wr_en,
  input  logic [LOC_W-1:0] wr_loc,
  input  logic [1:0]       wr_sel,
  input  logic [3:0]       wr_be,
  input  logic [31:0]      wr_data,
  input  logic [LOC_W-1:0] rd_loc,
  input  logic [1:0]       rd_sel,
  output logic [31:0]      rd_data,
  output logic             irq
);
  localparam int SRC_N = 4;
  localparam logic [LOC_W-1:0] NLOC = LOC_W'(NUM_LOC);
  localparam logic [1:0] SEL_ENA = 2'd0;
  localparam logic [1:0] SEL_STS = 2'd1;
  localparam logic [1:0] SEL_VEC = 2'd2;
  localparam logic [31:0] SRC_MASK = 32'((1 << SRC_N) - 1);
  localparam logic [31:0] POL_MASK = 32'(((1 << POL_W) - 1) << POL_LSB);
  localparam logic [31:0] ENA_MASK = (32'd1 << GEN_BIT) | POL_MASK | SRC_MASK;
  localparam logic [31:0] ENA_RST  = 32'd1 << POL_LSB;

  logic [NUM_LOC-1:0][31:0]      ena_q;
  logic [NUM_LOC-1:0][SRC_N-1:0] sts_q;
  logic [NUM_LOC-1:0]            set_any, drop;
  logic                          irq_q;

  wire [SRC_N-1:0] evt_vec = {evt_sv, evt_da, evt_cr, evt_lc};
  wire             evt_ok  = evt_loc < NLOC;
  wire             wr_ok   = wr_en && (active_loc < NLOC) && (wr_loc == active_loc);
  wire [31:0]      lane    = {{8{wr_be[3]}}, {8{wr_be[2]}}, {8{wr_be[1]}}, {8{wr_be[0]}}};

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
    wire hit_evt = evt_ok && (evt_loc == LOC_W'(i)) && ena_q[i][GEN_BIT];
    wire hit_wr  = wr_ok && (wr_loc == LOC_W'(i));
    wire [SRC_N-1:0] set_v = hit_evt ? (evt_vec & ena_q[i][SRC_N-1:0]) : '0;
    wire [SRC_N-1:0] clr_v = (hit_wr && wr_sel == SEL_STS) ?
                             (wr_data[SRC_N-1:0] & lane[SRC_N-1:0]) : '0;
    wire [SRC_N-1:0] sts_d = (sts_q[i] & ~clr_v) | set_v;

    assign set_any[i] = |set_v;
    assign drop[i]    = (|clr_v) && (|sts_q[i]) && (sts_d == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ena_q[i] <= ENA_RST;
        sts_q[i] <= '0;
      end else begin
        sts_q[i] <= sts_d;
        if (hit_wr && wr_sel == SEL_ENA)
          ena_q[i] <= (ena_q[i] & ~lane) | (wr_data & lane & ENA_MASK);
      end
    end

    // R2
    sts_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(sts_q[i] & ~$past(sts_q[i]))) |-> $past(ena_q[i][GEN_BIT]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          irq_q <= 1'b0;
    else if (|set_any)   irq_q <= 1'b1;
    else if (|drop)      irq_q <= 1'b0;
  end

  assign irq = irq_q;

  always_comb begin
    rd_data = '0;
    if (rd_sel == SEL_VEC)
      rd_data = 32'(IRQ_LINE & 15);
    else if (rd_loc < NLOC) begin
      if (rd_sel == SEL_ENA)      rd_data = ena_q[rd_loc];
      else if (rd_sel == SEL_STS) rd_data = {{(32-SRC_N){1'b0}}, sts_q[rd_loc]};
    end
  end

  // R5
  foreign_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ok) |=> $stable(ena_q));

  // R4
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(evt_ok && (|evt_vec)));

  // R7
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_ok && wr_sel == SEL_STS));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_any) |=> irq);
endmodule

// File: tb/loc_irq_unit_bench.sv
module loc_irq_unit_bench;
  localparam int LINE = 11;
  localparam int OP_W = 1, OP_E = 2, OP_R = 3, OP_I = 4, OP_A = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [2:0]  active_loc, evt_loc, wr_loc, rd_loc;
  logic        evt_lc, evt_cr, evt_da, evt_sv, wr_en;
  logic [1:0]  wr_sel, rd_sel;
  logic [3:0]  wr_be;
  logic [31:0] wr_data, rd_data;
  logic        irq;

  loc_irq_unit #(.IRQ_LINE(LINE)) u_loc_irq_unit (
    .clk(clk), .rst_n(rst_n), .active_loc(active_loc), .evt_loc(evt_loc),
    .evt_lc(evt_lc), .evt_cr(evt_cr), .evt_da(evt_da), .evt_sv(evt_sv),
    .wr_en(wr_en), .wr_loc(wr_loc), .wr_sel(wr_sel), .wr_be(wr_be),
    .wr_data(wr_data), .rd_loc(rd_loc), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq(irq));

  function automatic logic [79:0] mk(int r, int op, int loc, int sel, int be,
                                     logic [31:0] d, logic [31:0] e);
    return {4'(r), 3'(op), 3'(loc), 2'(sel), 4'(be), d, e};
  endfunction

  localparam int NV = 64;
  localparam logic [79:0] VEC [NV] = '{
    mk(0, OP_A, 0, 0, 0, 0, 0),
    mk(1, OP_R, 0, 0, 0, 0, 32'h10),                     // R1
    mk(0, OP_W, 0, 0, 15, 32'hFFFF_FFFF, 0),
    mk(6, OP_R, 0, 0, 0, 0, 32'h8000_003F),              // R6
    mk(0, OP_E, 0, 0, 0, 32'hF, 0),
    mk(2, OP_R, 0, 1, 0, 0, 32'hF),                      // R2
    mk(2, OP_I, 0, 0, 0, 0, 1),                          // R2
    mk(0, OP_W, 0, 1, 15, 32'h1, 0),
    mk(7, OP_R, 0, 1, 0, 0, 32'hE),                      // R7
    mk(7, OP_I, 0, 0, 0, 0, 1),                          // R7
    mk(0, OP_W, 0, 1, 15, 32'hFFFF_FFF0, 0),
    mk(7, OP_R, 0, 1, 0, 0, 32'hE),                      // R7
    mk(0, OP_W, 0, 1, 15, 32'hE, 0),
    mk(7, OP_R, 0, 1, 0, 0, 0),                          // R7
    mk(7, OP_I, 0, 0, 0, 0, 0),                          // R7
    mk(0, OP_W, 1, 0, 15, 32'hFFFF_FFFF, 0),
    mk(5, OP_R, 1, 0, 0, 0, 32'h10),                     // R5
    mk(0, OP_E, 1, 0, 0, 32'hF, 0),
    mk(3, OP_R, 1, 1, 0, 0, 0),                          // R3
    mk(0, OP_A, 7, 0, 0, 0, 0),
    mk(0, OP_W, 0, 0, 15, 0, 0),
    mk(0, OP_A, 0, 0, 0, 0, 0),
    mk(5, OP_R, 0, 0, 0, 0, 32'h8000_003F),              // R5
    mk(0, OP_W, 0, 0, 15, 32'h0000_000F, 0),
    mk(6, OP_R, 0, 0, 0, 0, 32'h0000_000F),              // R6
    mk(0, OP_E, 0, 0, 0, 32'hF, 0),
    mk(3, OP_R, 0, 1, 0, 0, 0),                          // R3
    mk(3, OP_I, 0, 0, 0, 0, 0),                          // R3
    mk(0, OP_W, 0, 0, 15, 32'h8000_0002, 0),
    mk(0, OP_E, 0, 0, 0, 32'hF, 0),
    mk(2, OP_R, 0, 1, 0, 0, 32'h2),                      // R2
    mk(2, OP_I, 0, 0, 0, 0, 1),                          // R2
    mk(0, OP_E, 7, 0, 0, 32'hF, 0),
    mk(0, OP_W, 0, 1, 15, 32'h2, 0),
    mk(7, OP_I, 0, 0, 0, 0, 0),                          // R7
    mk(0, OP_E, 5, 0, 0, 32'hF, 0),
    mk(4, OP_I, 0, 0, 0, 0, 0),                          // R4
    mk(0, OP_W, 0, 0, 8, 32'h0000_003F, 0),
    mk(8, OP_R, 0, 0, 0, 0, 32'h0000_0002),              // R8
    mk(0, OP_W, 0, 0, 1, 32'h8000_0031, 0),
    mk(8, OP_R, 0, 0, 0, 0, 32'h0000_0031),              // R8
    mk(0, OP_W, 0, 0, 3, 32'h0000_0010, 0),
    mk(8, OP_R, 0, 0, 0, 0, 32'h0000_0010),              // R8
    mk(9, OP_R, 0, 2, 0, 0, LINE),                       // R9
    mk(0, OP_W, 0, 2, 15, 0, 0),
    mk(9, OP_R, 3, 2, 0, 0, LINE),                       // R9
    mk(0, OP_W, 0, 0, 15, 32'h8000_000F, 0),
    mk(0, OP_A, 1, 0, 0, 0, 0),
    mk(0, OP_W, 1, 0, 15, 32'h8000_000F, 0),
    mk(0, OP_E, 1, 0, 0, 32'h1, 0),
    mk(0, OP_A, 0, 0, 0, 0, 0),
    mk(0, OP_E, 0, 0, 0, 32'h2, 0),
    mk(0, OP_W, 0, 1, 15, 32'h2, 0),
    mk(11, OP_I, 0, 0, 0, 0, 0),                         // R11
    mk(11, OP_R, 1, 1, 0, 0, 32'h1),                     // R11
    mk(0, OP_A, 1, 0, 0, 0, 0),
    mk(0, OP_W, 1, 1, 15, 32'h1, 0),
    mk(11, OP_R, 1, 1, 0, 0, 0),                         // R11
    mk(0, OP_E, 1, 0, 0, 32'hF, 0),
    mk(0, OP_W, 1, 1, 14, 32'hF, 0),
    mk(8, OP_R, 1, 1, 0, 0, 32'hF),                      // R8
    mk(0, OP_W, 1, 1, 1, 32'hF, 0),
    mk(8, OP_I, 0, 0, 0, 0, 0),                          // R8
    mk(8, OP_R, 1, 1, 0, 0, 0)                           // R8
  };

  int applied = 0;
  int bad = 0;

  task automatic chk(int r, logic [31:0] act, logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; evt_lc = 0; evt_cr = 0; evt_da = 0; evt_sv = 0;
  endtask

  task automatic wr(int loc, int sel, int be, logic [31:0] d);
    wr_en = 1; wr_loc = 3'(loc); wr_sel = 2'(sel); wr_be = 4'(be); wr_data = d;
  endtask

  task automatic ev(int loc, logic [3:0] s);
    evt_loc = 3'(loc); {evt_sv, evt_da, evt_cr, evt_lc} = s;
  endtask

  task automatic rd(int loc, int sel);
    rd_loc = 3'(loc); rd_sel = 2'(sel); #1;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; active_loc = 7; evt_loc = 0; wr_loc = 0; wr_sel = 0; wr_be = 0;
    wr_data = 0; rd_loc = 0; rd_sel = 0; idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(1, {31'd0, irq}, 0);                             // R1

    for (int k = 0; k < NV; k++) begin
      logic [79:0] v;
      int r, op, loc, sel, be;
      v = VEC[k];
      r = int'(v[79:76]); op = int'(v[75:73]); loc = int'(v[72:70]);
      sel = int'(v[69:68]); be = int'(v[67:64]);
      idle();
      case (op)
        OP_A: active_loc = 3'(loc);
        OP_W: wr(loc, sel, be, v[63:32]);
        OP_E: ev(loc, v[35:32]);
        OP_R: begin rd(loc, sel); chk(r, rd_data, v[31:0]); end
        OP_I: begin #1; chk(r, {31'd0, irq}, v[31:0]); end
        default: ;
      endcase
      @(negedge clk);
    end
    idle();

    // R1: reset clears everything even with the line high
    ev(1, 4'h1); @(negedge clk); idle();
    chk(2, {31'd0, irq}, 1);                             // R2
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
    chk(1, {31'd0, irq}, 0);                             // R1
    rd(1, 1); chk(1, rd_data, 0);                        // R1
    rd(1, 0); chk(1, rd_data, 32'h10);                   // R1
    rd(3, 0); chk(1, rd_data, 32'h10);                   // R1

    // R10: event and clear in one cycle
    active_loc = 0;
    wr(0, 0, 15, 32'h8000_000F); @(negedge clk); idle();
    ev(0, 4'h1); @(negedge clk); idle();
    wr(0, 1, 15, 32'h1); ev(0, 4'h1); @(negedge clk); idle();
    rd(0, 1); chk(10, rd_data, 32'h1);                   // R10
    chk(10, {31'd0, irq}, 1);                            // R10
    wr(0, 1, 15, 32'h1); ev(0, 4'h4); @(negedge clk); idle();
    rd(0, 1); chk(10, rd_data, 32'h4);                   // R10
    chk(10, {31'd0, irq}, 1);                            // R10
    wr(0, 1, 15, 32'h4); @(negedge clk); idle();
    chk(7, {31'd0, irq}, 0);                             // R7

    finish_run();
  end
endmodule